// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block turns single-word host reads and writes into the strobe sequence of a small dynamic memory. The memory inside the block is eight byte-wide chips driven in lockstep. Every chip sees the same row and column index on one shared narrow address bus, and the eight chips together hold a 64-bit word.

The controller keeps track of one open row. For an access to a row that is not open, it first closes any other open row and writes that row back to the array. It then opens the new row, which copies it into each chip's line buffer, and then strobes the column. An access to the row that is already open issues only a column strobe.

A free-running interval timer raises refresh requests. A refresh is taken between host accesses. It closes the open row first, then re-opens and writes back one row. Successive refreshes cycle through the rows.

The host side uses a valid/ready request port. `req_ready` stays low until the response pulse for the accepted request has been issued. A one-cycle `rsp_valid` pulse carries the read data (or the written data, for a write) together with a flag that reports whether the access found its row already open.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and no row is open, so the first access reports `rsp_hit`=0 with closed-row latency.
- R2: A read of (row, col) returns the 64-bit word stored there. Bits 8k+7..8k come from chip k, and all eight chips are addressed with the same (row, col). The result is delivered with one `rsp_valid` pulse.
- R3: A write stores `req_wdata` at (row, col), and its response pulse echoes the written word on `rsp_rdata`. A later read returns the new word, including a read issued while that row is still open and has not yet been written back.
- R4: With no row open, the row strobe is issued first and the column strobe follows no earlier than T_RCD cycles later. `rsp_valid` rises T_RCD+2 cycles after the accepting clock edge.
- R5: An access to a row other than the open one precharges the open row first. The next row strobe comes no earlier than T_RP cycles after the precharge. `rsp_valid` rises T_RP+T_RCD+2 cycles after acceptance, and at most one strobe is active in any cycle.
- R6: An access to the open row issues only a column strobe. `rsp_valid` rises 2 cycles after acceptance with `rsp_hit`=1. Every other access reports `rsp_hit`=0.
- R7: After a request is accepted, `req_ready` is 0 from the next cycle until the controller is idle again, so no second request is taken meanwhile.
- R8: A refresh falls due every T_REFI cycles and is taken before the next host request, with `req_ready` held at 0 while it runs. It precharges an open row first and leaves no row open, so the following access is a miss. Stored data survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | 2 | Row index |
| req_col | input | 2 | Column index |
| req_wdata | input | 64 | Write word, byte k to chip k |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Access found its row already open |
| rsp_rdata | output | 64 | Read word, or echoed write word |

## Verification
The bench sweeps every cell row by row and column by column, and checks data, hit flag and latency against a model that tracks the open row. Several corner cases get explicit attention:

- A read issued right after a write to the same open row catches a design that reads the array instead of the line buffer; such a design returns stale data.
- Column-order sweeps force a precharge on every access. A missing write-back loses data, and a skipped precharge wait shows up as a short latency.
- Any stall seen before acceptance marks a refresh. The access that follows must then be a miss with unchanged data, so a refresh that leaves the row marked open, or that corrupts a row, is reported.

// File: rtl/mdram_pkg.sv
package mdram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_DATA,
    ST_RACT,
    ST_RPRE
  } seq_state_t;
endpackage

// File: rtl/mdram_lane.sv
module mdram_lane #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int LW   = 8,
  localparam int RAW = $clog2(ROWS),
  localparam int CAW = $clog2(COLS),
  localparam int AW  = (RAW > CAW) ? RAW : CAW
) (
  input  logic          clk,
  input  logic          ras,
  input  logic          cas,
  input  logic          pre,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] wdata,
  output logic [LW-1:0] rdata
);
  localparam int LINE_W = COLS * LW;

  logic [LINE_W-1:0] cells [ROWS];
  logic [LINE_W-1:0] line_q;
  logic [LW-1:0]     rd_q;
  logic [RAW-1:0]    row_idx;
  logic [CAW-1:0]    col_idx;

  assign row_idx = addr[RAW-1:0];
  assign col_idx = addr[CAW-1:0];

  // array write port: precharge stores the line buffer back
  always_ff @(posedge clk) begin
    if (pre) cells[row_idx] <= line_q;
  end

  // row open copies a row into the line buffer; column ops work on the buffer
  always_ff @(posedge clk) begin
    if (ras) line_q <= cells[row_idx];
    else if (cas && we) line_q[col_idx*LW +: LW] <= wdata;
    if (cas && !we) rd_q <= line_q[col_idx*LW +: LW];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/mdram_refresh_timer.sv
module mdram_refresh_timer #(
  parameter int T_REFI = 64,
  localparam int CW = $clog2(T_REFI + 1)
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [CW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (cnt_q == CW'(T_REFI - 1));
      cnt_q  <= (cnt_q == CW'(T_REFI - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/mdram_seq.sv
module mdram_seq
  import mdram_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int DW    = 64,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  localparam int RAW  = $clog2(ROWS),
  localparam int CAW  = $clog2(COLS),
  localparam int AW   = (RAW > CAW) ? RAW : CAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ref_tick,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [RAW-1:0] req_row,
  input  logic [CAW-1:0] req_col,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic           rsp_hit,
  output logic [DW-1:0]  rsp_rdata,
  output logic           cmd_ras,
  output logic           cmd_cas,
  output logic           cmd_pre,
  output logic           cmd_we,
  output logic [AW-1:0]  cmd_addr,
  output logic [DW-1:0]  cmd_wdata,
  input  logic [DW-1:0]  lane_rdata
);
  localparam int TMAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int GW   = TW + 1;

  seq_state_t     state;
  logic [TW-1:0]  tmr;
  logic           open_q;
  logic [RAW-1:0] open_row_q;
  logic           ref_pend;
  logic [RAW-1:0] ref_row_q;
  logic           pre_for_ref;
  logic           wr_q;
  logic           hit_q;
  logic [RAW-1:0] row_q;
  logic [CAW-1:0] col_q;
  logic [DW-1:0]  wdata_q;

  always_comb req_ready = (state == ST_IDLE) && !ref_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tmr         <= '0;
      open_q      <= 1'b0;
      open_row_q  <= '0;
      ref_pend    <= 1'b0;
      ref_row_q   <= '0;
      pre_for_ref <= 1'b0;
      wr_q        <= 1'b0;
      hit_q       <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
      wdata_q     <= '0;
      cmd_ras     <= 1'b0;
      cmd_cas     <= 1'b0;
      cmd_pre     <= 1'b0;
      cmd_we      <= 1'b0;
      cmd_addr    <= '0;
      cmd_wdata   <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      cmd_ras   <= 1'b0;
      cmd_cas   <= 1'b0;
      cmd_pre   <= 1'b0;
      cmd_we    <= 1'b0;
      rsp_valid <= 1'b0;
      if (ref_tick) ref_pend <= 1'b1;

      unique case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            if (open_q) begin
              state       <= ST_PRE;
              pre_for_ref <= 1'b1;
              cmd_pre     <= 1'b1;
              cmd_addr    <= AW'(open_row_q);
              tmr         <= TW'(T_RP - 1);
              open_q      <= 1'b0;
            end else begin
              state    <= ST_RACT;
              cmd_ras  <= 1'b1;
              cmd_addr <= AW'(ref_row_q);
              tmr      <= TW'(T_RCD - 1);
              ref_pend <= 1'b0;
            end
          end else if (req_valid) begin
            wr_q    <= req_write;
            row_q   <= req_row;
            col_q   <= req_col;
            wdata_q <= req_wdata;
            if (open_q && (open_row_q == req_row)) begin
              hit_q     <= 1'b1;
              state     <= ST_COL;
              cmd_cas   <= 1'b1;
              cmd_we    <= req_write;
              cmd_addr  <= AW'(req_col);
              cmd_wdata <= req_wdata;
            end else if (open_q) begin
              hit_q       <= 1'b0;
              state       <= ST_PRE;
              pre_for_ref <= 1'b0;
              cmd_pre     <= 1'b1;
              cmd_addr    <= AW'(open_row_q);
              tmr         <= TW'(T_RP - 1);
              open_q      <= 1'b0;
            end else begin
              hit_q      <= 1'b0;
              state      <= ST_ACT;
              cmd_ras    <= 1'b1;
              cmd_addr   <= AW'(req_row);
              tmr        <= TW'(T_RCD - 1);
              open_q     <= 1'b1;
              open_row_q <= req_row;
            end
          end
        end
        ST_PRE: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else if (pre_for_ref) begin
            state    <= ST_RACT;
            cmd_ras  <= 1'b1;
            cmd_addr <= AW'(ref_row_q);
            tmr      <= TW'(T_RCD - 1);
            ref_pend <= 1'b0;
          end else begin
            state      <= ST_ACT;
            cmd_ras    <= 1'b1;
            cmd_addr   <= AW'(row_q);
            tmr        <= TW'(T_RCD - 1);
            open_q     <= 1'b1;
            open_row_q <= row_q;
          end
        end
        ST_ACT: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            state     <= ST_COL;
            cmd_cas   <= 1'b1;
            cmd_we    <= wr_q;
            cmd_addr  <= AW'(col_q);
            cmd_wdata <= wdata_q;
          end
        end
        ST_COL: state <= ST_DATA;
        ST_DATA: begin
          state     <= ST_IDLE;
          rsp_valid <= 1'b1;
          rsp_hit   <= hit_q;
          rsp_rdata <= wr_q ? wdata_q : lane_rdata;
        end
        ST_RACT: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            state    <= ST_RPRE;
            cmd_pre  <= 1'b1;
            cmd_addr <= AW'(ref_row_q);
            tmr      <= TW'(T_RP - 1);
          end
        end
        ST_RPRE: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            state     <= ST_IDLE;
            ref_row_q <= ref_row_q + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // spacing counters for the strobe timing checks
  logic [GW-1:0] since_ras, since_pre;
  always_ff @(posedge clk) begin
    if (rst) begin
      since_ras <= '1;
      since_pre <= '1;
    end else begin
      since_ras <= cmd_ras ? GW'(1) : ((since_ras == '1) ? since_ras : since_ras + 1'b1);
      since_pre <= cmd_pre ? GW'(1) : ((since_pre == '1) ? since_pre : since_pre + 1'b1);
    end
  end

  assert_rcd_gap_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_cas |-> (since_ras >= GW'(T_RCD)));
  assert_rp_gap_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_ras |-> (since_pre >= GW'(T_RP)));
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_ras, cmd_cas, cmd_pre}));
  assert_cas_needs_row_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_cas |-> open_q);
  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  assert_refresh_closed_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RACT) |-> !open_q);
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 2,
  parameter int T_REFI = 64,
  localparam int RAW   = $clog2(ROWS),
  localparam int CAW   = $clog2(COLS),
  localparam int AW    = (RAW > CAW) ? RAW : CAW,
  localparam int DW    = LANES * LANE_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [RAW-1:0] req_row,
  input  logic [CAW-1:0] req_col,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic           rsp_hit,
  output logic [DW-1:0]  rsp_rdata
);
  logic          ref_tick;
  logic          cmd_ras, cmd_cas, cmd_pre, cmd_we;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic [DW-1:0] lane_rdata;

  mdram_refresh_timer #(.T_REFI(T_REFI)) u_refresh (
    .clk  (clk),
    .rst  (rst),
    .tick (ref_tick)
  );

  mdram_seq #(
    .ROWS(ROWS), .COLS(COLS), .DW(DW), .T_RCD(T_RCD), .T_RP(T_RP)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ref_tick   (ref_tick),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_row    (req_row),
    .req_col    (req_col),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_rdata  (rsp_rdata),
    .cmd_ras    (cmd_ras),
    .cmd_cas    (cmd_cas),
    .cmd_pre    (cmd_pre),
    .cmd_we     (cmd_we),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .lane_rdata (lane_rdata)
  );

  // eight chips in lockstep, chip k owns byte lane k
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    mdram_lane #(.ROWS(ROWS), .COLS(COLS), .LW(LANE_W)) u_chip (
      .clk   (clk),
      .ras   (cmd_ras),
      .cas   (cmd_cas),
      .pre   (cmd_pre),
      .we    (cmd_we),
      .addr  (cmd_addr),
      .wdata (cmd_wdata[k*LANE_W +: LANE_W]),
      .rdata (lane_rdata[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: tb/tb_dram_mux_ctrl.sv
`timescale 1ns/1ps
module tb_dram_mux_ctrl;
  localparam int ROWS = 4, COLS = 4, T_RCD = 2, T_RP = 2, T_REFI = 64;

  logic        clk = 0;
  logic        rst;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_row, req_col;
  logic [63:0] req_wdata;
  logic        rsp_valid, rsp_hit;
  logic [63:0] rsp_rdata;

  always #4 clk = ~clk;

  dram_mux_ctrl #(.T_RCD(T_RCD), .T_RP(T_RP), .T_REFI(T_REFI)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_rdata(rsp_rdata)
  );

  int total = 0, bad = 0, hits = 0, misses = 0, refreshes = 0;
  logic [63:0] model [ROWS*COLS];
  bit m_open = 0;
  int m_row = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(int r, int c, int s);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = 8'(s*37 + r*53 + c*11 + k*29 + 1);
    return v;
  endfunction

  task automatic access(input bit wr, input int r, input int c, input logic [63:0] wd);
    bit stalled = 0;
    bit exp_hit;
    int exp_lat, lat;
    logic [63:0] exp_data;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_row = 2'(r); req_col = 2'(c); req_wdata = wd;
    while (!req_ready) begin stalled = 1; @(negedge clk); end
    if (stalled) begin refreshes++; m_open = 0; end
    exp_hit = m_open && (m_row == r);
    exp_lat = exp_hit ? 2 : (m_open ? 2 + T_RP + T_RCD : 2 + T_RCD);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R7 ready low after accept", 64'(req_ready), 64'd0);
    lat = 0;
    while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
    exp_data = wr ? wd : model[r*COLS + c];
    if (wr) model[r*COLS + c] = wd;
    chk(wr ? "R3 write echo" : "R2 read data", rsp_rdata, exp_data);
    chk(stalled ? "R8 miss after refresh" : (exp_hit ? "R6 hit flag" : "R4 R5 miss flag"),
        64'(rsp_hit), 64'(exp_hit));
    chk(exp_hit ? "R6 hit latency" : (m_open ? "R5 precharge latency" : "R4 open latency"),
        64'(lat), 64'(exp_lat));
    if (rsp_hit) hits++; else misses++;
    m_open = 1; m_row = r;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    req_valid = 0; req_write = 0; req_row = 0; req_col = 0; req_wdata = 0;
    rst = 1;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    chk("R1 no response after reset", 64'(rsp_valid), 64'd0);

    // R3: fill row-major (mostly row hits), R1 first access is a closed-row miss
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) access(1, r, c, pat(r, c, 1));
    // R2: read back row-major
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) access(0, r, c, '0);
    // R5: column-major reads force a precharge on every access
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) access(0, r, c, '0);
    // R3 R5: overwrite column-major, then read row-major
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) access(1, r, c, pat(r, c, 7));
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) access(0, r, c, '0);
    // R3: read-after-write in the open row, several rounds so refreshes land in between
    for (int n = 0; n < 40; n++) begin
      access(1, n % ROWS, (n / 4) % COLS, pat(n, n, 11));
      access(0, n % ROWS, (n / 4) % COLS, '0);
    end
    // R8: data intact after all refreshes
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) access(0, r, c, '0);

    chk("R8 refresh observed", 64'(refreshes > 0), 64'd1);
    chk("R6 some row hits", 64'(hits > 0), 64'd1);
    chk("R5 some row misses", 64'(misses > 0), 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule